// File: doc/BRIEF.md
# Short Transfer Report Queue

This block keeps a log of transfers that finished before reaching their programmed byte count, for example when a streaming producer closed its packet early. Each early-ended transfer that was submitted with reporting enabled produces one record. The record holds the 5-bit transfer tag and the count of bytes actually moved. Records wait in a small first-in first-out store until software collects them.

Software sees the oldest record through two register views. The length view can be read any number of times. A read of the tag view removes the record. A summary flag in bit 31 of the completion word is set while any record is still waiting. Software repeats the read of the length and then the tag until that flag reads 0. If the store is already full, a new record is discarded and a sticky overflow flag is set. The data path and the completion bookkeeping of the other bits sit outside this block. Bits 30 to 0 of the completion word are passed straight through.

Top module: `short_xfer_log`

## Requirements
- R1: While `rst_n` is low, and after it is released, the queue is empty: `pending` = 0, `overflow` = 0, `head_id` = 0, `head_len` = 0.
- R2: An edge with `ev_valid`=1 and `ev_report`=1 stores the record {`ev_id`, `ev_len`}, and `pending` goes to 1 after that edge. An event with `ev_report`=0 stores nothing and leaves every output unchanged.
- R3: `head_id` and `head_len` always show the oldest stored record, and records leave in arrival order. While `pop_strobe` is low, the head does not change, however many cycles pass.
- R4: An edge with `pop_strobe`=1 removes the head record. A pop while the queue is empty has no effect.
- R5: `done_word[31]` equals `pending`, and `done_word[30:0]` equals `done_in[30:0]` in the same cycle.
- R6: When DEPTH records are stored and no pop occurs on the same edge, a new reporting event is dropped and `overflow` becomes 1. `overflow` then stays 1 until reset, and the stored records are unchanged.
- R7: A pop and a reporting event on the same edge with a full queue are both carried out. The queue stays full, the new record goes to the tail, and `overflow` is not set.
- R8: When the queue is empty, `head_id` and `head_len` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | A transfer ended short this cycle |
| ev_report | input | 1 | That transfer was submitted with reporting enabled |
| ev_id | input | ID_W | Tag of the short transfer |
| ev_len | input | LEN_W | Bytes actually moved |
| pop_strobe | input | 1 | Tag view was read; remove the head |
| done_in | input | 31 | Per-tag completion bits from the scheduler |
| head_id | output | ID_W | Tag of the oldest record, 0 when empty |
| head_len | output | LEN_W | Byte count of the oldest record, 0 when empty |
| pending | output | 1 | At least one record is waiting |
| overflow | output | 1 | Sticky: a record was dropped |
| done_word | output | 32 | Completion word with the summary flag in bit 31 |

## Verification
The bench drives the edges of the store directly. It fills the queue to DEPTH and pushes once more. A design that wraps the write pointer would overwrite the oldest record, and a design without the sticky flag would lose the overflow report. It pops and pushes together on a full queue. A design that checks fullness before the pop would drop that record or raise a false overflow. It also pops an empty queue, where a broken counter would underflow and show `pending`, and it sends events with reporting disabled, which must leave no trace. A random phase then checks the order of records and the unchanged head during repeated length reads against a queue model kept in the bench.

// File: rtl/short_xfer_log.sv
module short_xfer_log #(
  parameter int DEPTH = 8,
  parameter int ID_W  = 5,
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_valid,
  input  logic             ev_report,
  input  logic [ID_W-1:0]  ev_id,
  input  logic [LEN_W-1:0] ev_len,
  input  logic             pop_strobe,
  input  logic [30:0]      done_in,
  output logic [ID_W-1:0]  head_id,
  output logic [LEN_W-1:0] head_len,
  output logic             pending,
  output logic             overflow,
  output logic [31:0]      done_word
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int RW = ID_W + LEN_W;

  logic [RW-1:0] slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  wire push_req = ev_valid & ev_report;
  wire full     = (count == CW'(DEPTH));
  wire pop_ok   = pop_strobe & (count != '0);
  wire push_ok  = push_req & (~full | pop_ok);
  wire drop     = push_req & full & ~pop_ok;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (push_ok) begin
        slot[wr_ptr] <= {ev_id, ev_len};
        wr_ptr       <= nxt(wr_ptr);
      end
      if (pop_ok) rd_ptr <= nxt(rd_ptr);
      count <= count + CW'(push_ok) - CW'(pop_ok);
      if (drop) overflow <= 1'b1;
    end
  end

  assign pending   = (count != '0);
  assign head_id   = pending ? slot[rd_ptr][RW-1:LEN_W] : '0;
  assign head_len  = pending ? slot[rd_ptr][LEN_W-1:0]  : '0;
  assign done_word = {pending, done_in};

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R6
  AST_DROP_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop_strobe) |=> (overflow && count == CW'(DEPTH))); // R6
  AST_FILTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !(ev_valid && ev_report)) |=> !pending); // R2
  AST_POP_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_strobe && pending && !push_req) |=> (count == $past(count) - CW'(1))); // R4
  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && pop_strobe && full && !overflow) |=> (full && !overflow)); // R7
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !pop_strobe) |=> ($stable(head_id) && $stable(head_len))); // R3
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R6
endmodule

// File: tb/test_short_xfer_log.sv
module test_short_xfer_log;
  localparam int DEPTH = 8;
  localparam int ID_W  = 5;
  localparam int LEN_W = 24;

  logic clk = 1'b0;
  logic rst_n;
  logic ev_valid, ev_report, pop_strobe;
  logic [ID_W-1:0] ev_id;
  logic [LEN_W-1:0] ev_len;
  logic [30:0] done_in;
  logic [ID_W-1:0] head_id;
  logic [LEN_W-1:0] head_len;
  logic pending, overflow;
  logic [31:0] done_word;

  int n_chk = 0;
  int n_bad = 0;
  logic [ID_W-1:0]  m_id [$];
  logic [LEN_W-1:0] m_len [$];
  logic m_ovf;

  short_xfer_log #(.DEPTH(DEPTH), .ID_W(ID_W), .LEN_W(LEN_W)) i_short_xfer_log (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_report(ev_report),
    .ev_id(ev_id), .ev_len(ev_len), .pop_strobe(pop_strobe), .done_in(done_in),
    .head_id(head_id), .head_len(head_len), .pending(pending),
    .overflow(overflow), .done_word(done_word));

  always #10 clk = ~clk;

  task automatic check(input string req, input string what, input longint got, input longint exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [ID_W-1:0] exp_id();
    return (m_id.size() > 0) ? m_id[0] : '0;
  endfunction

  function automatic logic [LEN_W-1:0] exp_len();
    return (m_len.size() > 0) ? m_len[0] : '0;
  endfunction

  task automatic check_all();
    check("R2", "pending", pending, m_id.size() > 0);
    check(m_id.size() > 0 ? "R3" : "R8", "head_id", head_id, exp_id());
    check(m_id.size() > 0 ? "R3" : "R8", "head_len", head_len, exp_len());
    check("R6", "overflow", overflow, m_ovf);
    check("R5", "done_word", done_word, {m_id.size() > 0, done_in});
  endtask

  task automatic step(input logic v, input logic rep, input logic [ID_W-1:0] id,
                      input logic [LEN_W-1:0] len, input logic pop, input logic [30:0] dn);
    logic pop_eff, push;
    ev_valid = v; ev_report = rep; ev_id = id; ev_len = len; pop_strobe = pop; done_in = dn;
    @(posedge clk);
    pop_eff = pop && (m_id.size() > 0);
    push = v && rep;
    if (push && m_id.size() == DEPTH && !pop_eff) m_ovf = 1'b1;
    else if (push) begin m_id.push_back(id); m_len.push_back(len); end
    if (pop_eff) begin void'(m_id.pop_front()); void'(m_len.pop_front()); end
    @(negedge clk);
    ev_valid = 0; ev_report = 0; pop_strobe = 0;
    check_all();
  endtask

  task automatic do_reset();
    rst_n = 0; ev_valid = 0; ev_report = 0; ev_id = '0; ev_len = '0;
    pop_strobe = 0; done_in = '0;
    m_id.delete(); m_len.delete(); m_ovf = 0;
    repeat (3) @(negedge clk);
    check("R1", "pending in reset", pending, 0);
    check("R1", "overflow in reset", overflow, 0);
    rst_n = 1;
    @(negedge clk);
    check("R1", "head_id after reset", head_id, 0);
    check("R1", "head_len after reset", head_len, 0);
    check_all();
  endtask

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    // R2: reporting disabled leaves no record
    step(1, 0, 5'd3, 24'd100, 0, 31'h1);
    check("R2", "filtered event", pending, 0);
    // R4: pop on empty has no effect
    step(0, 0, '0, '0, 1, 31'h2);
    check("R4", "pop empty", pending, 0);
    // R2/R3: two records, head held across idle length reads
    step(1, 1, 5'd7, 24'h000040, 0, 31'h0);
    step(1, 1, 5'd19, 24'h123456, 0, 31'h0);
    repeat (3) step(0, 0, '0, '0, 0, 31'h5a5a);
    check("R3", "head held", head_id, 5'd7);
    step(0, 0, '0, '0, 1, 31'h0);
    check("R4", "pop order", head_id, 5'd19);
    step(0, 0, '0, '0, 1, 31'h0);
    check("R8", "empty after pops", head_len, 0);
    // R6: fill, then one extra dropped
    for (int k = 0; k < DEPTH; k++) step(1, 1, ID_W'(k + 1), LEN_W'(k * 16 + 8), 0, 31'h0);
    step(1, 1, 5'd31, 24'hffffff, 0, 31'h0);
    check("R6", "drop sets overflow", overflow, 1);
    check("R6", "head unchanged", head_id, 5'd1);
    // R7: pop+push on full
    do_reset();
    for (int k = 0; k < DEPTH; k++) step(1, 1, ID_W'(k + 2), LEN_W'(k + 100), 0, 31'h0);
    step(1, 1, 5'd30, 24'habcdef, 1, 31'h0);
    check("R7", "no overflow on swap", overflow, 0);
    check("R7", "head advanced", head_id, 5'd3);
    for (int k = 0; k < DEPTH - 1; k++) step(0, 0, '0, '0, 1, 31'h0);
    check("R7", "swapped record at tail", head_len, 24'habcdef);
    // random phase
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[0] | r[1], r[2] | r[3], ID_W'($urandom), LEN_W'($urandom),
           (r[7:4] < 4'd6), 31'($urandom));
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule